// File: doc/BRIEF.md
# Programmable Despreading Code Correlator

This block despreads a direct-sequence spread-spectrum baseband stream. Soft I and Q chip samples arrive at chip rate with a valid strobe. Each chip is multiplied by one bit of a programmable spreading code of up to 16 chips and summed over a symbol. One code serves both paths. The code arrives as two 8-bit configuration bytes that together form a 16-bit field. A shorter code sits in the low-order bits, and its highest active bit is applied to the first chip of a symbol.

A symbol-start strobe, raised together with the valid of a symbol's first chip, aligns the correlator. On that chip the code bytes and the length are captured. When the final chip of the symbol has been taken in, the two signed sums appear on the outputs for one cycle with a valid pulse. They are then held until the next result. The next symbol may begin on the very next chip.

Top module: `dsc_correlator`

## Requirements
- R1: While reset is asserted and right after it, `sumValid` is 0 and both sums read 0.
- R2: The active code is `{codeHi, codeLo}`, using its low `L` bits, where `L` is the captured length. The first chip of a symbol uses bit `L-1` and the last chip uses bit 0. With `L` equal to 1, the single chip ends the symbol at once.
- R3: A code bit of 1 adds the chip sample to the sum and a code bit of 0 subtracts it. The same code bit is applied to the I and Q samples of a chip.
- R4: The sums are 13-bit two's complement. Sixteen full-scale 8-bit samples do not wrap: -128 with code bit 0 sums to +2048, and with code bit 1 to -2048.
- R5: The clock edge that takes in the L-th chip of a symbol loads both sums and raises `sumValid` for exactly that one cycle. The sums then hold their value until the next result.
- R6: A symbol start on the chip right after a completed symbol loses no chip, and the new sum contains none of the old one.
- R7: Code bytes and length are sampled only on a chip that carries the symbol-start strobe. Changes during a symbol have no effect on that symbol.
- R8: The following are all ignored: cycles without `chipValid`, chips before the first symbol start, chips after a symbol completes but before the next start, and a symbol-start strobe without `chipValid`.
- R9: A symbol start arriving before the current symbol is complete discards the partial sums and begins a new symbol with that chip.
- R10: A length value of 0, or any value above 16, is treated as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipValid | input | 1 | Qualifies the chip samples this cycle |
| symStart | input | 1 | Marks the first chip of a symbol (with chipValid) |
| chipI | input | 8 | Signed I chip sample |
| chipQ | input | 8 | Signed Q chip sample |
| codeHi | input | 8 | Upper byte of the despreading code |
| codeLo | input | 8 | Lower byte of the despreading code |
| codeLen | input | 5 | Code length in chips, 1 to 16 (0 or above 16 means 16) |
| sumValid | output | 1 | One-cycle pulse when new sums are presented |
| sumI | output | 13 | Signed I correlation sum |
| sumQ | output | 13 | Signed Q correlation sum |

## Verification
The hardest situation to reach is the symbol boundary with no idle chip in between. There, one edge both dumps the old sum and seeds the new one, possibly with a different code and length. A single-chip symbol collapses both roles into the same chip. The stimulus drives back-to-back symbols, single-chip symbols, restarts in mid-symbol and code changes in mid-symbol. A long random run then mixes gaps in the valid strobe, random starts and out-of-range lengths. A behavioural model is compared with the outputs after every clock.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  // Per-chip command from control to datapath.
  typedef struct packed {
    logic load;    // first chip of a symbol: seed accumulator
    logic accum;   // later chip: add to accumulator
    logic dump;    // last chip: present result and clear
    logic addSel;  // 1 = add sample, 0 = subtract sample
  } dsc_strobe_t;
endpackage

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
  import dsc_pkg::*;
#(
  parameter int MAX_CHIPS = 16,
  localparam int CODE_W = MAX_CHIPS,
  localparam int HALF_W = CODE_W / 2,
  localparam int LEN_W  = $clog2(MAX_CHIPS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipValid,
  input  logic              symStart,
  input  logic [HALF_W-1:0] codeHi,
  input  logic [HALF_W-1:0] codeLo,
  input  logic [LEN_W-1:0]  codeLen,
  output dsc_strobe_t       strb
);
  logic [CODE_W-1:0] codeIn, codeReg, shStart, shRun;
  logic [LEN_W-1:0]  effLen, lenReg, idx;
  logic              active, startHit, runHit;

  assign codeIn   = {codeHi, codeLo};
  assign effLen   = (codeLen == '0 || codeLen > LEN_W'(MAX_CHIPS)) ? LEN_W'(MAX_CHIPS) : codeLen;
  assign startHit = chipValid & symStart;
  assign runHit   = chipValid & active & ~symStart;

  always_comb begin
    strb    = '0;
    shStart = codeIn >> (effLen - LEN_W'(1));
    shRun   = codeReg >> (lenReg - LEN_W'(1) - idx);
    if (startHit) begin
      strb.load   = 1'b1;
      strb.addSel = shStart[0];
      strb.dump   = (effLen == LEN_W'(1));
    end else if (runHit) begin
      strb.accum  = 1'b1;
      strb.addSel = shRun[0];
      strb.dump   = (idx == lenReg - LEN_W'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeReg <= '0;
      lenReg  <= LEN_W'(MAX_CHIPS);
      idx     <= '0;
      active  <= 1'b0;
    end else if (startHit) begin
      codeReg <= codeIn;
      lenReg  <= effLen;
      idx     <= LEN_W'(1);
      active  <= (effLen != LEN_W'(1));
    end else if (runHit) begin
      idx <= idx + LEN_W'(1);
      if (strb.dump) active <= 1'b0;
    end
  end
endmodule

// File: rtl/dsc_lane.sv
module dsc_lane
  import dsc_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int SUM_W    = 13
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dsc_strobe_t                strb,
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic signed [SUM_W-1:0]    sum
);
  logic signed [SUM_W-1:0] acc, ext, term, nxt;

  always_comb begin
    ext  = SUM_W'(sample);
    term = strb.addSel ? ext : -ext;
    nxt  = (strb.load ? '0 : acc) + term;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
      sum <= '0;
    end else if (strb.dump) begin
      sum <= nxt;
      acc <= '0;
    end else if (strb.load || strb.accum) begin
      acc <= nxt;
    end
  end
endmodule

// File: rtl/dsc_datapath.sv
module dsc_datapath
  import dsc_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int SUM_W    = 13,
  localparam int NUM_LANES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dsc_strobe_t                strb,
  input  logic signed [SAMPLE_W-1:0] sampI,
  input  logic signed [SAMPLE_W-1:0] sampQ,
  output logic                       sumValid,
  output logic signed [SUM_W-1:0]    sumI,
  output logic signed [SUM_W-1:0]    sumQ
);
  logic signed [SAMPLE_W-1:0] samp    [NUM_LANES];
  logic signed [SUM_W-1:0]    laneSum [NUM_LANES];

  assign samp[0] = sampI;
  assign samp[1] = sampQ;

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    dsc_lane #(.SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)) uLane (
      .clk(clk), .rstN(rstN), .strb(strb), .sample(samp[g]), .sum(laneSum[g])
    );
  end

  assign sumI = laneSum[0];
  assign sumQ = laneSum[1];

  always_ff @(posedge clk) begin
    if (!rstN) sumValid <= 1'b0;
    else       sumValid <= strb.dump;
  end
endmodule

// File: rtl/dsc_correlator.sv
module dsc_correlator
  import dsc_pkg::*;
#(
  parameter int SAMPLE_W  = 8,
  parameter int MAX_CHIPS = 16,
  localparam int HALF_W = MAX_CHIPS / 2,
  localparam int LEN_W  = $clog2(MAX_CHIPS + 1),
  localparam int SUM_W  = SAMPLE_W + $clog2(MAX_CHIPS) + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       chipValid,
  input  logic                       symStart,
  input  logic signed [SAMPLE_W-1:0] chipI,
  input  logic signed [SAMPLE_W-1:0] chipQ,
  input  logic [HALF_W-1:0]          codeHi,
  input  logic [HALF_W-1:0]          codeLo,
  input  logic [LEN_W-1:0]           codeLen,
  output logic                       sumValid,
  output logic signed [SUM_W-1:0]    sumI,
  output logic signed [SUM_W-1:0]    sumQ
);
  dsc_strobe_t strb;

  dsc_ctrl #(.MAX_CHIPS(MAX_CHIPS)) uCtrl (
    .clk(clk), .rstN(rstN), .chipValid(chipValid), .symStart(symStart),
    .codeHi(codeHi), .codeLo(codeLo), .codeLen(codeLen), .strb(strb)
  );

  dsc_datapath #(.SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .sampI(chipI), .sampQ(chipQ),
    .sumValid(sumValid), .sumI(sumI), .sumQ(sumQ)
  );
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int SAMPLE_W  = 8,
  parameter int MAX_CHIPS = 16,
  parameter int LEN_W     = 5,
  parameter int SUM_W     = 13
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    chipValid,
  input logic                    symStart,
  input logic [LEN_W-1:0]        codeLen,
  input logic                    sumValid,
  input logic signed [SUM_W-1:0] sumI,
  input logic signed [SUM_W-1:0] sumQ
);
  localparam int LIM = MAX_CHIPS * (2 ** (SAMPLE_W - 1));

  // R5: a result only follows a clock edge that took in a chip
  p_valid_follows_chip_r5: assert property (@(posedge clk) disable iff (!rstN)
    sumValid |-> $past(chipValid));

  // R5: sums hold while no new result is presented
  p_hold_between_r5: assert property (@(posedge clk) disable iff (!rstN)
    !sumValid |-> ($stable(sumI) && $stable(sumQ)));

  // R2: a one-chip code completes its symbol at once
  p_single_chip_symbol_r2: assert property (@(posedge clk) disable iff (!rstN)
    (chipValid && symStart && codeLen == LEN_W'(1)) |=> sumValid);

  // R4: results stay within the full-scale bound
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    sumValid |-> (sumI <= LIM && sumI >= -LIM && sumQ <= LIM && sumQ >= -LIM));
endmodule

bind dsc_correlator dsc_checker #(
  .SAMPLE_W(SAMPLE_W), .MAX_CHIPS(MAX_CHIPS), .LEN_W(LEN_W), .SUM_W(SUM_W)
) uChk (
  .clk(clk), .rstN(rstN), .chipValid(chipValid), .symStart(symStart),
  .codeLen(codeLen), .sumValid(sumValid), .sumI(sumI), .sumQ(sumQ)
);

// File: tb/sim_dsc_correlator.sv
`timescale 1ns/1ps
module sim_dsc_correlator;
  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              chipValid = 1'b0, symStart = 1'b0;
  logic signed [7:0] chipI = '0, chipQ = '0;
  logic [7:0]        codeHi = '0, codeLo = '0;
  logic [4:0]        codeLen = 5'd1;
  logic              sumValid;
  logic signed [12:0] sumI, sumQ;

  int errors = 0, checks = 0;
  bit done = 0;
  string curReq = "R1";

  // model state
  int mActive = 0, mIdx = 0, mLen = 16, mCode = 0, mAccI = 0, mAccQ = 0;
  bit eValid = 0;
  int eI = 0, eQ = 0;

  always #10 clk = ~clk;

  dsc_correlator u0 (
    .clk(clk), .rstN(rstN), .chipValid(chipValid), .symStart(symStart),
    .chipI(chipI), .chipQ(chipQ), .codeHi(codeHi), .codeLo(codeLo),
    .codeLen(codeLen), .sumValid(sumValid), .sumI(sumI), .sumQ(sumQ)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelDump();
    eValid = 1; eI = mAccI; eQ = mAccQ; mActive = 0;
  endtask

  task automatic modelStep();
    int b, i, q;
    eValid = 0;
    if (!rstN) begin
      mActive = 0; eI = 0; eQ = 0;
      return;
    end
    i = int'(chipI); q = int'(chipQ);
    if (chipValid && symStart) begin
      mLen  = (codeLen == 0 || codeLen > 16) ? 16 : int'(codeLen);
      mCode = {codeHi, codeLo};
      b = (mCode >> (mLen - 1)) & 1;
      mAccI = b ? i : -i; mAccQ = b ? q : -q;
      mIdx = 1;
      if (mLen == 1) modelDump(); else mActive = 1;
    end else if (chipValid && mActive != 0) begin
      b = (mCode >> (mLen - 1 - mIdx)) & 1;
      mAccI += b ? i : -i; mAccQ += b ? q : -q;
      mIdx++;
      if (mIdx == mLen) modelDump();
    end
  endtask

  // drive one cycle, update the model at the edge, compare after it
  task automatic cyc(bit v, bit s, int i, int q);
    chipValid = v; symStart = s; chipI = 8'(i); chipQ = 8'(q);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    check({curReq, " model valid"}, int'(sumValid), int'(eValid));
    check({curReq, " model sumI"}, int'(sumI), eI);
    check({curReq, " model sumQ"}, int'(sumQ), eQ);
  endtask

  task automatic setCode(int hi, int lo, int len);
    codeHi = 8'(hi); codeLo = 8'(lo); codeLen = 5'(len);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int samp [8] = '{1, 2, 4, 8, 16, 32, 64, 100};
    // R1: reset
    repeat (3) cyc(0, 0, 0, 0);
    check("R1 valid in reset", int'(sumValid), 0);
    check("R1 sumI in reset", int'(sumI), 0);
    rstN = 1'b1;
    // R8: chips before any start are ignored
    curReq = "R8";
    for (int k = 0; k < 5; k++) cyc(1, 0, 50, -50);
    check("R8 pre-start valid", int'(sumValid), 0);
    // R2/R3: code 0x00A5 length 8, MSB first
    curReq = "R2";
    setCode(8'h00, 8'hA5, 8);
    for (int k = 0; k < 8; k++) cyc(1, k == 0, samp[k], -samp[k]);
    check("R2 valid on last chip", int'(sumValid), 1);
    check("R3 sumI msb-first", int'(sumI), 47);
    check("R3 sumQ same code", int'(sumQ), -47);
    cyc(0, 0, 0, 0);
    check("R5 pulse one cycle", int'(sumValid), 0);
    check("R5 sumI held", int'(sumI), 47);
    // R4: full scale
    curReq = "R4";
    setCode(0, 0, 16);
    for (int k = 0; k < 16; k++) cyc(1, k == 0, -128, 127);
    check("R4 sumI +2048", int'(sumI), 2048);
    check("R4 sumQ -2032", int'(sumQ), -2032);
    setCode(8'hFF, 8'hFF, 16);
    for (int k = 0; k < 16; k++) cyc(1, k == 0, -128, -128);
    check("R4 sumI -2048", int'(sumI), -2048);
    // R6: back-to-back symbols, code 0b10 length 2
    curReq = "R6";
    setCode(0, 2, 2);
    cyc(1, 1, 5, 0); cyc(1, 0, 3, 0);
    check("R6 first sum", int'(sumI), 2);
    cyc(1, 1, 7, 0);
    check("R6 no valid mid", int'(sumValid), 0);
    cyc(1, 0, 1, 0);
    check("R6 second sum", int'(sumI), 6);
    check("R6 second valid", int'(sumValid), 1);
    // R7: code and length change mid-symbol ignored
    curReq = "R7";
    setCode(0, 8'h0F, 4);
    cyc(1, 1, 3, 1);
    setCode(0, 0, 2);
    cyc(1, 0, 3, 1); cyc(1, 0, 3, 1);
    check("R7 no early end", int'(sumValid), 0);
    cyc(1, 0, 3, 1);
    check("R7 sumI old code", int'(sumI), 12);
    // R8: post-symbol chips and start without valid ignored
    curReq = "R8";
    cyc(1, 0, 40, 40); cyc(1, 0, 40, 40);
    cyc(0, 1, 40, 40);
    check("R8 ignored valid", int'(sumValid), 0);
    check("R8 ignored sum", int'(sumI), 12);
    setCode(0, 1, 1);
    cyc(1, 1, 9, -9);
    check("R2 single chip sum", int'(sumI), 9);
    check("R2 single chip valid", int'(sumValid), 1);
    // R9: restart mid-symbol
    curReq = "R9";
    setCode(0, 8'h0F, 4);
    cyc(1, 1, 10, 10); cyc(1, 0, 10, 10);
    setCode(0, 3, 2);
    cyc(1, 1, 1, 1); cyc(1, 0, 1, 1);
    check("R9 restart sum", int'(sumI), 2);
    // R10: out-of-range lengths mean 16
    curReq = "R10";
    setCode(8'hFF, 8'hFF, 0);
    for (int k = 0; k < 16; k++) cyc(1, k == 0, 1, 2);
    check("R10 len0 sum", int'(sumI), 16);
    setCode(8'hFF, 8'hFF, 20);
    for (int k = 0; k < 15; k++) cyc(1, k == 0, 1, 2);
    check("R10 len20 not done", int'(sumValid), 0);
    cyc(1, 0, 1, 2);
    check("R10 len20 sumQ", int'(sumQ), 32);
    // random mix against the model
    curReq = "R5";
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 9) == 0)
        setCode($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 31));
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 11) == 0,
          $urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule